// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block sits beside a DRAM access controller. It takes care of two things. The first is the start-up sequence: a long quiet pause, then a fixed number of RAS-pulsing wake-up cycles. The second is steady-state refresh. Until the wake-up cycles are complete, `init_done` stays low and the controller must not issue normal traffic. After that, an interval timer adds one owed refresh for every slice of the refresh period. With 512 rows, that is one slice every 8 ms / 512 ≈ 15.6 µs. The scheduler raises `ref_req` while anything is owed.

When the controller answers `ref_req` with `ref_grant`, the scheduler drives one CAS-before-RAS refresh cycle directly on the strobes. All CAS lines fall first. RAS follows after a setup time. CAS is held low for a hold time after RAS falls. RAS then stays low for the rest of the active time, and both strobes precharge. The DRAM supplies the row address itself, so no address is driven.

Owed refreshes build up when grants come late. The count saturates, and `ref_urgent` then tells the controller to leave page mode. If one more interval expires at saturation, the refresh period is taken as lost and the wake-up sequence runs again. A grant given while `self_req` is high turns the cycle into a self-refresh entry. The strobes then stay low until the request drops and the minimum self-refresh time has passed, followed by a longer precharge.

Top module: `rs_sched`

## Requirements
- R1: For the whole reset period and for PAUSE_CYC cycles after reset release, `ref_req` and `init_done` are 0 and all strobes are high (1). `ref_req` first rises PAUSE_CYC cycles after reset release.
- R2: During wake-up, `ref_req` is high whenever no strobe cycle is running. `init_done` rises on the same edge that ends the WAKE_CNT-th completed refresh cycle.
- R3: In every refresh cycle, all `cas_n` lines go low CSR_CYC cycles before `ras_n` falls, and `ras_n` never falls while `cas_n` is high.
- R4: A normal refresh cycle runs through these stages, with strobe values {ras_n,cas_n}:
  - CSR_CYC cycles of {1,0}
  - CHR_CYC cycles of {0,0}
  - RAS_CYC cycles of {0,1}
  - RP_CYC cycles of {1,1}
  - then `busy` returns to 0.
- R5: After wake-up, `owed_cnt` rises by one every INTERVAL_CYC cycles. It falls by one on the edge that ends a normal refresh cycle. When both happen on the same edge, it is unchanged.
- R6: `owed_cnt` never exceeds OWED_MAX. `ref_urgent` is 1 exactly when `owed_cnt` equals OWED_MAX.
- R7: If an interval expires while `owed_cnt` is at OWED_MAX and no refresh ends on that edge, the following happen on that edge:
  - `init_done` falls
  - `owed_cnt` clears to 0
  - the wake-up sequence of R2 starts over.
- R8: `ref_grant` has no effect while `ref_req` is 0, including during the pause. `busy` stays 0.
- R9: A grant given while `self_req` is 1 after wake-up starts a self-refresh entry. After the setup and hold stages, `self_active` is 1 with both strobes low. This state lasts at least SELF_CYC cycles and ends only on an edge where `self_req` is 0.
- R10: On self-refresh exit, the strobes stay high for RPS_CYC cycles, and then `busy` falls. Intervals that expire during a self-refresh cycle are not counted, and `owed_cnt` is 0 when the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | Controller accepts the pending refresh |
| self_req | input | 1 | Makes the next granted cycle a self-refresh entry; held high to stay in self refresh |
| ref_req | output | 1 | A refresh (wake-up or owed) is wanted |
| ref_urgent | output | 1 | Owed count saturated; stop page mode and refresh |
| init_done | output | 1 | Pause and wake-up complete; normal traffic allowed |
| owed_cnt | output | $clog2(OWED_MAX+1) | Number of refreshes owed |
| busy | output | 1 | A strobe cycle is running |
| self_active | output | 1 | Device is held in self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | NCAS | Column strobes, active low, driven together |

## Verification
Every output comes from a flop that loads on the rising edge where its cause is seen. A grant raises `busy` and changes the strobes on that same edge, and `ref_req` drops with it. `init_done` and `owed_cnt` change on the edge that ends the last precharge cycle, and an interval adds to the count on the edge where the timer wraps. The reference model in the bench steps on that same rising edge, using the inputs driven at the preceding falling edge. Every output is compared at the next falling edge, so each result is checked in the cycle it is due and never one edge early or late.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    IST_PAUSE,
    IST_WAKE,
    IST_RUN
  } init_st_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_HOLD,
    SQ_TAIL,
    SQ_SELF,
    SQ_PRE
  } seq_st_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
  } strobe_t;

  // Strobe levels belonging to each sequencer stage.
  function automatic strobe_t strobe_of(seq_st_e s);
    strobe_t v;
    case (s)
      SQ_SETUP: v = '{ras_n: 1'b1, cas_n: 1'b0};
      SQ_HOLD:  v = '{ras_n: 1'b0, cas_n: 1'b0};
      SQ_SELF:  v = '{ras_n: 1'b0, cas_n: 1'b0};
      SQ_TAIL:  v = '{ras_n: 1'b0, cas_n: 1'b1};
      default:  v = '{ras_n: 1'b1, cas_n: 1'b1};
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rs_interval.sv
// Free-running interval timer; one-cycle tick each INTERVAL_CYC cycles while run is high.
module rs_interval #(
  parameter int INTERVAL_CYC = 1562
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int TW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] tcnt;

  assign tick = run && (tcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      tcnt <= '0;
    end else if (tcnt == LAST) begin
      tcnt <= '0;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end
endmodule

// File: rtl/rs_owed.sv
// Saturating owed-refresh counter with overrun detection.
module rs_owed #(
  parameter int OWED_MAX = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           run,
  input  logic                           inc,
  input  logic                           dec,
  input  logic                           clr,
  output logic [$clog2(OWED_MAX+1)-1:0]  owed,
  output logic                           at_max,
  output logic                           overrun
);
  localparam int OW = $clog2(OWED_MAX + 1);
  localparam logic [OW-1:0] FULL = OW'(OWED_MAX);

  logic take;

  assign at_max  = (owed == FULL);
  assign take    = dec && (owed != '0);
  assign overrun = run && inc && at_max && !take;

  always_ff @(posedge clk) begin
    if (rst || clr || overrun) begin
      owed <= '0;
    end else if (run) begin
      case ({inc, take})
        2'b10:   if (!at_max) owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end
endmodule

// File: rtl/rs_strobe.sv
// CAS-before-RAS strobe sequencer, with optional self-refresh hold.
module rs_strobe
  import rs_pkg::*;
#(
  parameter int CSR_CYC  = 1,
  parameter int CHR_CYC  = 1,
  parameter int RAS_CYC  = 5,
  parameter int RP_CYC   = 4,
  parameter int SELF_CYC = 10000,
  parameter int RPS_CYC  = 11,
  parameter int NCAS     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            self_mode,
  input  logic            self_req,
  output logic            ras_n,
  output logic [NCAS-1:0] cas_n,
  output logic            busy,
  output logic            in_self,
  output logic            self_cyc,
  output logic            done
);
  localparam int M1   = (CSR_CYC > CHR_CYC) ? CSR_CYC : CHR_CYC;
  localparam int M2   = (RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC;
  localparam int M3   = (SELF_CYC > RPS_CYC) ? SELF_CYC : RPS_CYC;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int MAXL = (M12 > M3) ? M12 : M3;
  localparam int CW   = $clog2(MAXL + 1);

  localparam logic [CW-1:0] CSR_L  = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] CHR_L  = CW'(CHR_CYC - 1);
  localparam logic [CW-1:0] RAS_L  = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] RP_L   = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] SELF_L = CW'(SELF_CYC - 1);
  localparam logic [CW-1:0] RPS_L  = CW'(RPS_CYC - 1);

  seq_st_e       st, st_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          self_l;
  logic [CW-1:0] pre_last;
  strobe_t       lv_d;
  logic          cas_q;

  assign pre_last = self_l ? RPS_L : RP_L;
  assign done     = (st == SQ_PRE) && (cnt == pre_last);
  assign self_cyc = self_l;

  always_comb begin
    st_d  = st;
    cnt_d = cnt + 1'b1;
    case (st)
      SQ_IDLE: begin
        cnt_d = '0;
        if (start) st_d = SQ_SETUP;
      end
      SQ_SETUP: if (cnt == CSR_L) begin
        st_d  = SQ_HOLD;
        cnt_d = '0;
      end
      SQ_HOLD: if (cnt == CHR_L) begin
        st_d  = self_l ? SQ_SELF : SQ_TAIL;
        cnt_d = '0;
      end
      SQ_TAIL: if (cnt == RAS_L) begin
        st_d  = SQ_PRE;
        cnt_d = '0;
      end
      SQ_SELF: if (cnt == SELF_L) begin
        cnt_d = cnt;
        if (!self_req) begin
          st_d  = SQ_PRE;
          cnt_d = '0;
        end
      end
      SQ_PRE: if (cnt == pre_last) begin
        st_d  = SQ_IDLE;
        cnt_d = '0;
      end
      default: begin
        st_d  = SQ_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  assign lv_d = strobe_of(st_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      cnt     <= '0;
      self_l  <= 1'b0;
      ras_n   <= 1'b1;
      cas_q   <= 1'b1;
      busy    <= 1'b0;
      in_self <= 1'b0;
    end else begin
      st      <= st_d;
      cnt     <= cnt_d;
      ras_n   <= lv_d.ras_n;
      cas_q   <= lv_d.cas_n;
      busy    <= (st_d != SQ_IDLE);
      in_self <= (st_d == SQ_SELF);
      if (st == SQ_IDLE && start) self_l <= self_mode;
    end
  end

  // Every byte-lane column strobe follows the same registered level.
  for (genvar g = 0; g < NCAS; g++) begin : g_cas
    assign cas_n[g] = cas_q;
  end
endmodule

// File: rtl/rs_sched.sv
// Top: power-up pause, wake-up cycles, distributed refresh with owed count.
module rs_sched
  import rs_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int PAUSE_CYC    = CLK_MHZ * 200,
  parameter int INTERVAL_CYC = (CLK_MHZ * 8000) / 512,
  parameter int WAKE_CNT     = 8,
  parameter int OWED_MAX     = 8,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int RAS_CYC      = 5,
  parameter int RP_CYC       = 4,
  parameter int SELF_CYC     = CLK_MHZ * 100,
  parameter int RPS_CYC      = 11,
  parameter int NCAS         = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ref_grant,
  input  logic                          self_req,
  output logic                          ref_req,
  output logic                          ref_urgent,
  output logic                          init_done,
  output logic [$clog2(OWED_MAX+1)-1:0] owed_cnt,
  output logic                          busy,
  output logic                          self_active,
  output logic                          ras_n,
  output logic [NCAS-1:0]               cas_n
);
  localparam int PW = (PAUSE_CYC > 2) ? $clog2(PAUSE_CYC) : 1;
  localparam int WW = $clog2(WAKE_CNT + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WAKE_CNT - 1);

  init_st_e      st;
  logic [PW-1:0] pcnt;
  logic [WW-1:0] wcnt;
  logic          run, tick, start, seq_done, seq_self, self_busy;
  logic          owed_full, overrun;

  assign run       = (st == IST_RUN);
  assign ref_req   = !busy && ((st == IST_WAKE) || (run && owed_cnt != '0));
  assign start     = ref_req && ref_grant;
  assign self_busy = busy && seq_self;
  assign ref_urgent = owed_full;

  rs_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_tmr (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  rs_owed #(.OWED_MAX(OWED_MAX)) u_owed (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .inc    (tick && !self_busy),
    .dec    (seq_done && !seq_self),
    .clr    (seq_done && seq_self),
    .owed   (owed_cnt),
    .at_max (owed_full),
    .overrun(overrun)
  );

  rs_strobe #(
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC),
    .SELF_CYC(SELF_CYC),
    .RPS_CYC (RPS_CYC),
    .NCAS    (NCAS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .self_mode(self_req && run),
    .self_req (self_req),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .busy     (busy),
    .in_self  (self_active),
    .self_cyc (seq_self),
    .done     (seq_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= IST_PAUSE;
      pcnt      <= '0;
      wcnt      <= '0;
      init_done <= 1'b0;
    end else begin
      case (st)
        IST_PAUSE: begin
          if (pcnt == P_LAST) st <= IST_WAKE;
          else                pcnt <= pcnt + 1'b1;
        end
        IST_WAKE: begin
          if (seq_done) begin
            if (wcnt == W_LAST) begin
              st        <= IST_RUN;
              init_done <= 1'b1;
              wcnt      <= '0;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
        end
        IST_RUN: begin
          if (overrun) begin
            st        <= IST_WAKE;
            init_done <= 1'b0;
            wcnt      <= '0;
          end
        end
        default: st <= IST_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
  parameter int OWED_MAX = 8,
  parameter int NCAS     = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          ref_grant,
  input logic                          ref_req,
  input logic                          ref_urgent,
  input logic                          init_done,
  input logic [$clog2(OWED_MAX+1)-1:0] owed_cnt,
  input logic                          busy,
  input logic                          self_active,
  input logic                          ras_n,
  input logic [NCAS-1:0]               cas_n
);
  a_r1_idle_strobes_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ras_n && cas_n == '1));

  a_r2_done_ends_cycle: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> ($past(busy) && !busy));

  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> ($past(cas_n) == '0));

  a_r4_cas_low_at_ras_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (cas_n == '0));

  a_r5_owed_single_step: assert property (@(posedge clk) disable iff (rst)
    ##1 ((int'(owed_cnt) == int'($past(owed_cnt))) ||
         (int'(owed_cnt) == int'($past(owed_cnt)) + 1) ||
         (int'(owed_cnt) + 1 == int'($past(owed_cnt))) ||
         (owed_cnt == '0)));

  a_r6_owed_bounded: assert property (@(posedge clk) disable iff (rst)
    int'(owed_cnt) <= OWED_MAX);

  a_r7_rewake_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(init_done) |-> (owed_cnt == '0 && !ref_urgent));

  a_r8_busy_needs_grant: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(ref_req && ref_grant)) |=> !busy);

  a_r9_self_strobes_low: assert property (@(posedge clk) disable iff (rst)
    self_active |-> (!ras_n && cas_n == '0));

  a_r10_self_exit_precharge: assert property (@(posedge clk) disable iff (rst)
    $fell(self_active) |-> (ras_n && busy));
endmodule

bind rs_sched rs_sched_chk #(.OWED_MAX(OWED_MAX), .NCAS(NCAS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ref_grant  (ref_grant),
  .ref_req    (ref_req),
  .ref_urgent (ref_urgent),
  .init_done  (init_done),
  .owed_cnt   (owed_cnt),
  .busy       (busy),
  .self_active(self_active),
  .ras_n      (ras_n),
  .cas_n      (cas_n)
);

// File: tb/rs_sched_tb_top.sv
module rs_sched_tb_top;
  localparam int PAUSE    = 20;
  localparam int INTERVAL = 40;
  localparam int WAKE     = 8;
  localparam int OMAX     = 8;
  localparam int CSR      = 1;
  localparam int CHR      = 2;
  localparam int RASC     = 3;
  localparam int RP       = 2;
  localparam int SELFC    = 25;
  localparam int RPS      = 4;
  localparam int NCAS     = 2;
  localparam int OW       = $clog2(OMAX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_grant = 1'b0;
  logic self_req = 1'b0;
  logic ref_req, ref_urgent, init_done, busy, self_active, ras_n;
  logic [OW-1:0]   owed_cnt;
  logic [NCAS-1:0] cas_n;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit cmp_en = 0;

  always #5 clk = ~clk;

  rs_sched #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTERVAL), .WAKE_CNT(WAKE), .OWED_MAX(OMAX),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASC), .RP_CYC(RP),
    .SELF_CYC(SELFC), .RPS_CYC(RPS), .NCAS(NCAS)
  ) dut_i (
    .clk(clk), .rst(rst), .ref_grant(ref_grant), .self_req(self_req),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .init_done(init_done),
    .owed_cnt(owed_cnt), .busy(busy), .self_active(self_active),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // strobe code: bit1 = ras_n, bit0 = cas_n; 4 marks entry into self refresh
  int q[$];
  int m_ph, m_pc, m_wc, m_owed, m_tc, m_cur, m_sfc;
  bit m_init, m_busy, m_in_self, m_self_l;

  function automatic bit m_req();
    return !m_busy && (m_ph == 1 || (m_ph == 2 && m_owed > 0));
  endfunction

  always @(posedge clk) begin
    bit done_e, start, selfb, tick, inc, dec;
    int ph0, v;
    if (rst) begin
      m_ph = 0; m_pc = 0; m_wc = 0; m_owed = 0; m_tc = 0; m_cur = 3; m_sfc = 0;
      m_init = 0; m_busy = 0; m_in_self = 0; m_self_l = 0;
      q.delete();
    end else begin
      ph0    = m_ph;
      done_e = m_busy && !m_in_self && (q.size() == 0);
      start  = m_req() && ref_grant;
      selfb  = m_busy && m_self_l;
      tick   = (m_ph == 2) && (m_tc == INTERVAL - 1);
      // strobe timeline
      if (start) begin
        m_self_l = self_req && (m_ph == 2);
        for (int i = 0; i < CSR; i++) q.push_back(2);
        for (int i = 0; i < CHR; i++) q.push_back(0);
        if (m_self_l) q.push_back(4);
        else begin
          for (int i = 0; i < RASC; i++) q.push_back(1);
          for (int i = 0; i < RP; i++) q.push_back(3);
        end
        m_busy = 1;
        m_cur  = q.pop_front();
      end else if (m_busy) begin
        if (m_in_self) begin
          if (m_sfc >= SELFC && !self_req) begin
            m_in_self = 0;
            m_cur = 3;
            for (int i = 1; i < RPS; i++) q.push_back(3);
          end else m_sfc++;
        end else if (q.size() == 0) begin
          m_busy = 0;
          m_cur  = 3;
        end else begin
          v = q.pop_front();
          if (v == 4) begin
            m_in_self = 1; m_sfc = 1; m_cur = 0;
          end else m_cur = v;
        end
      end
      // sequencing of pause, wake-up and run
      case (ph0)
        0: if (m_pc == PAUSE - 1) m_ph = 1; else m_pc++;
        1: if (done_e) begin
             m_wc++;
             if (m_wc == WAKE) begin m_ph = 2; m_init = 1; m_wc = 0; end
           end
        default: begin
          inc = tick && !selfb;
          dec = done_e && !m_self_l && (m_owed > 0);
          if (done_e && m_self_l) m_owed = 0;
          else if (inc && !dec && m_owed == OMAX) begin
            m_ph = 1; m_init = 0; m_owed = 0; m_wc = 0;
          end else if (inc && !dec) m_owed++;
          else if (dec && !inc) m_owed--;
        end
      endcase
      m_tc = (ph0 == 2 && !tick) ? m_tc + 1 : 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int prev_ras = 1, prev_cas = 3;
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R1 ref_req", int'(ref_req), int'(m_req()));
      chk("R2 init_done", int'(init_done), int'(m_init));
      chk("R4 ras_n", int'(ras_n), (m_cur >> 1) & 1);
      chk("R4 cas_n", int'(cas_n), (m_cur & 1) ? 3 : 0);
      chk("R5 owed_cnt", int'(owed_cnt), m_owed);
      chk("R6 ref_urgent", int'(ref_urgent), int'(m_owed == OMAX));
      chk("R8 busy", int'(busy), int'(m_busy));
      chk("R9 self_active", int'(self_active), int'(m_in_self));
      if (prev_ras == 1 && ras_n == 1'b0) chk("R3 cas low before ras falls", prev_cas, 0);
      prev_ras = int'(ras_n);
      prev_cas = int'(cas_n);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    @(negedge clk);
    cmp_en = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset init_done", int'(init_done), 0);
    chk("R1 reset ras_n", int'(ras_n), 1);
    chk("R1 reset ref_req", int'(ref_req), 0);
    rst = 1'b0;
    ref_grant = 1'b1;                  // granted during pause: must be ignored
    repeat (PAUSE - 2) @(negedge clk);
    chk("R8 grant ignored in pause", int'(busy), 0);
    chk("R1 pause strobes high", int'(cas_n), 3);

    for (int i = 0; i < 2000 && !init_done; i++) @(negedge clk);
    chk("R2 wake-up completes", int'(init_done), 1);
    repeat (300) @(negedge clk);

    ref_grant = 1'b0;                  // starve refresh
    for (int i = 0; i < 1000 && !ref_urgent; i++) @(negedge clk);
    chk("R6 urgent at saturation", int'(owed_cnt), OMAX);
    for (int i = 0; i < 1000 && init_done; i++) @(negedge clk);
    chk("R7 rewake drops init_done", int'(init_done), 0);
    chk("R7 owed cleared", int'(owed_cnt), 0);
    ref_grant = 1'b1;
    for (int i = 0; i < 2000 && !init_done; i++) @(negedge clk);
    chk("R7 wake-up repeated", int'(init_done), 1);

    ref_grant = 1'b0;
    for (int i = 0; i < 1000 && owed_cnt != 2; i++) @(negedge clk);
    self_req  = 1'b1;
    ref_grant = 1'b1;
    for (int i = 0; i < 100 && !self_active; i++) @(negedge clk);
    repeat (60) @(negedge clk);
    chk("R9 held in self refresh", int'(self_active), 1);
    chk("R9 ras low in self refresh", int'(ras_n), 0);
    self_req = 1'b0;
    for (int i = 0; i < 100 && self_active; i++) @(negedge clk);
    chk("R10 precharge after self", int'(ras_n), 1);
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    chk("R10 owed zero after self", int'(owed_cnt), 0);
    repeat (200) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule